// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a small multi-cycle processor built around one 24-bit accumulator. Alongside the accumulator it keeps an instruction address register, a return address register, a stack pointer and a frame pointer. It fetches 24-bit instruction words from one synchronous, word-addressed memory port and runs them one at a time. The same port carries instructions and data. The instruction set has constant loads, direct loads and stores, loads and stores through a pointer word, loads and stores relative to the frame pointer, add and bitwise logic, an equality test, rotate, plain and sign-conditional jumps, call and return, and moves between the accumulator and the other registers.

An instruction word keeps its 4-bit primary opcode in bits 23..20 and a 20-bit address or constant in bits 19..0. Primary opcode F escapes to an 8-bit opcode in bits 23..16, and that form has a 16-bit constant in bits 15..0. The memory returns read data one cycle after it samples the address. It samples a write in the same cycle that the write strobe is high. The port has a fixed latency and no flow control: the memory never stalls the core and the core never needs to hold off the memory, so the port has no valid/ready handshake. The halt output goes high when the core runs its stop instruction and stays high until reset.

Top module: `acc_core`

## Requirements
- R1: While reset is high, every register is held at 0. In the first cycle after reset the core presents address 0 with the write strobe low and the halt output low.
- R2: Each fetch reads the word at the instruction address and then adds one to the instruction address. Bits 23..20 select the primary opcode: 0 LDC, 1 LDV, 2 STV, 3 ADD, 4 AND, 5 OR, 6 XOR, 7 EQL, 8 JMP, 9 JMN, A LDIV, B STIV, C CALL, D LDVR, E STVR, F escape.
- R3: LDC puts bits 19..0 of the instruction into the accumulator and clears accumulator bits 23..20. LDV copies the memory word at bits 19..0 into the accumulator. STV writes the accumulator to that address.
- R4: ADD adds the memory operand to the accumulator modulo 2^24. AND, OR and XOR combine the two bit by bit. Escape code F1 (NOT) inverts every accumulator bit.
- R5: EQL sets the accumulator to all ones when it equals the memory operand, and to 0 when it does not.
- R6: Escape code F2 rotates the accumulator right by one place. The old bit 0 moves into bit 23.
- R7: Escape code FA sign-extends instruction bits 15..0 to 24 bits and adds the result to the accumulator.
- R8: JMP loads the instruction address with bits 19..0. JMN does the same only when accumulator bit 23 is set, and otherwise leaves the instruction address unchanged.
- R9: CALL saves the already-incremented instruction address in the return register and then jumps. Escape F3 copies the return register into the instruction address. F4 copies the return register into the accumulator, and F5 copies the accumulator into the return register.
- R10: LDIV and STIV first read a pointer word at bits 19..0, then load from or store to the address held in bits 19..0 of that word.
- R11: LDVR and STVR reach the address formed by adding the frame pointer to bits 19..0, kept to 20 bits, so a field of FFFFF reaches the word just below the frame.
- R12: Escape codes F6 and F7 copy the stack pointer to the accumulator and the accumulator to the stack pointer. F8 and F9 do the same for the frame pointer.
- R13: Escape code F0 stops the core. From then until reset the halt output stays high, the write strobe stays low and the memory address holds still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W (20) | Word address for reads and writes |
| mem_wdata | output | DATA_W (24) | Write data, which is always the accumulator |
| mem_we | output | 1 | Write strobe |
| mem_rdata | input | DATA_W (24) | Read data for the address presented one cycle earlier |
| halted | output | 1 | High once the stop instruction has run |

## Verification
A fixed test program runs ADD, AND, OR, XOR, EQL, NOT, rotate, add-constant, constant load and JMN on every pair drawn from a set of seven operands. The set includes zero, one, the largest positive value, the most negative value, all ones, and two mixed patterns. The pairs with equal operands separate the two EQL outcomes. The all-ones and most-negative operands expose a lost carry or a wrong sign extension. The odd operands show whether the rotate wraps bit 0 into bit 23. The sign of the first operand selects the JMN path. A second program covers pointer, frame-relative, call and return, and register-move instructions. It uses a negative frame offset, a return address that the program overwrites, and a path that is skipped. The halt checks then watch the port for a stretch of idle cycles.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [2:0] {
    ST_FETCH, ST_LATCH, ST_EXEC, ST_PTR, ST_MEM, ST_HALT
  } state_t;

  localparam logic [3:0] OP_LDC  = 4'h0;
  localparam logic [3:0] OP_LDV  = 4'h1;
  localparam logic [3:0] OP_STV  = 4'h2;
  localparam logic [3:0] OP_ADD  = 4'h3;
  localparam logic [3:0] OP_AND  = 4'h4;
  localparam logic [3:0] OP_OR   = 4'h5;
  localparam logic [3:0] OP_XOR  = 4'h6;
  localparam logic [3:0] OP_EQL  = 4'h7;
  localparam logic [3:0] OP_JMP  = 4'h8;
  localparam logic [3:0] OP_JMN  = 4'h9;
  localparam logic [3:0] OP_LDIV = 4'hA;
  localparam logic [3:0] OP_STIV = 4'hB;
  localparam logic [3:0] OP_CALL = 4'hC;
  localparam logic [3:0] OP_LDVR = 4'hD;
  localparam logic [3:0] OP_STVR = 4'hE;
  localparam logic [3:0] OP_EXT  = 4'hF;

  localparam logic [7:0] EX_HALT = 8'hF0;
  localparam logic [7:0] EX_NOT  = 8'hF1;
  localparam logic [7:0] EX_RAR  = 8'hF2;
  localparam logic [7:0] EX_RET  = 8'hF3;
  localparam logic [7:0] EX_LDRA = 8'hF4;
  localparam logic [7:0] EX_STRA = 8'hF5;
  localparam logic [7:0] EX_LDSP = 8'hF6;
  localparam logic [7:0] EX_STSP = 8'hF7;
  localparam logic [7:0] EX_LDFP = 8'hF8;
  localparam logic [7:0] EX_STFP = 8'hF9;
  localparam logic [7:0] EX_ADC  = 8'hFA;

  typedef enum logic [3:0] {
    ALU_PASS, ALU_ADD, ALU_AND, ALU_OR, ALU_XOR, ALU_EQL,
    ALU_NOT, ALU_RAR, ALU_ADC, ALU_LDC
  } alu_op_t;

endpackage

// File: rtl/acc_core_decode.sv
module acc_core_decode
  import acc_core_pkg::*;
(
  input  logic [7:0] top_bits,
  output logic [3:0] pri,
  output logic [7:0] ext,
  output alu_op_t    alu_sel
);
  assign pri = top_bits[7:4];
  assign ext = top_bits;

  always_comb begin
    alu_sel = ALU_PASS;
    case (pri)
      OP_LDC: alu_sel = ALU_LDC;
      OP_ADD: alu_sel = ALU_ADD;
      OP_AND: alu_sel = ALU_AND;
      OP_OR:  alu_sel = ALU_OR;
      OP_XOR: alu_sel = ALU_XOR;
      OP_EQL: alu_sel = ALU_EQL;
      OP_EXT: begin
        case (ext)
          EX_NOT: alu_sel = ALU_NOT;
          EX_RAR: alu_sel = ALU_RAR;
          EX_ADC: alu_sel = ALU_ADC;
          default: alu_sel = ALU_PASS;
        endcase
      end
      default: alu_sel = ALU_PASS;
    endcase
  end
endmodule

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int CONST_W = 20,
  parameter int IMM_W   = 16
) (
  input  alu_op_t            sel,
  input  logic [DATA_W-1:0]  acc,
  input  logic [DATA_W-1:0]  opnd,
  input  logic [CONST_W-1:0] field,
  output logic [DATA_W-1:0]  result
);
  localparam int ZPAD = DATA_W - CONST_W;
  localparam int SPAD = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_sx;
  logic [DATA_W-1:0] const_zx;

  assign imm_sx   = {{SPAD{field[IMM_W-1]}}, field[IMM_W-1:0]};
  assign const_zx = {{ZPAD{1'b0}}, field};

  always_comb begin
    case (sel)
      ALU_ADD: result = acc + opnd;
      ALU_AND: result = acc & opnd;
      ALU_OR:  result = acc | opnd;
      ALU_XOR: result = acc ^ opnd;
      ALU_EQL: result = (acc == opnd) ? {DATA_W{1'b1}} : '0;
      ALU_NOT: result = ~acc;
      ALU_RAR: result = {acc[0], acc[DATA_W-1:1]};
      ALU_ADC: result = acc + imm_sx;
      ALU_LDC: result = const_zx;
      default: result = opnd;
    endcase
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);
  localparam int APAD = DATA_W - ADDR_W;

  state_t            state, n_state;
  logic [DATA_W-1:0] ir, acc, iar, ra, sp, fp;
  logic [DATA_W-1:0] n_ir, n_acc, n_iar, n_ra, n_sp, n_fp;
  logic [3:0]        pri;
  logic [7:0]        ext;
  alu_op_t           alu_sel;
  logic [DATA_W-1:0] alu_res;
  logic [ADDR_W-1:0] fld, rel_addr;
  logic [DATA_W-1:0] fld_zx;

  assign fld      = ir[ADDR_W-1:0];
  assign fld_zx   = {{APAD{1'b0}}, fld};
  assign rel_addr = fp[ADDR_W-1:0] + fld;

  acc_core_decode u_dec (
    .top_bits (ir[DATA_W-1 -: 8]),
    .pri      (pri),
    .ext      (ext),
    .alu_sel  (alu_sel)
  );

  acc_core_alu #(.DATA_W(DATA_W), .CONST_W(ADDR_W), .IMM_W(16)) u_alu (
    .sel    (alu_sel),
    .acc    (acc),
    .opnd   (mem_rdata),
    .field  (fld),
    .result (alu_res)
  );

  assign mem_wdata = acc;
  assign halted    = (state == ST_HALT);

  always_comb begin
    n_state  = state;
    n_ir     = ir;
    n_acc    = acc;
    n_iar    = iar;
    n_ra     = ra;
    n_sp     = sp;
    n_fp     = fp;
    mem_addr = iar[ADDR_W-1:0];
    mem_we   = 1'b0;
    case (state)
      ST_FETCH: n_state = ST_LATCH;
      ST_LATCH: begin
        n_ir    = mem_rdata;
        n_iar   = iar + 1'b1;
        n_state = ST_EXEC;
      end
      ST_EXEC: begin
        n_state = ST_FETCH;
        case (pri)
          OP_LDC: n_acc = alu_res;
          OP_LDV, OP_ADD, OP_AND, OP_OR, OP_XOR, OP_EQL: begin
            mem_addr = fld;
            n_state  = ST_MEM;
          end
          OP_STV: begin
            mem_addr = fld;
            mem_we   = 1'b1;
          end
          OP_JMP: n_iar = fld_zx;
          OP_JMN: if (acc[DATA_W-1]) n_iar = fld_zx;
          OP_CALL: begin
            n_ra  = iar;
            n_iar = fld_zx;
          end
          OP_LDIV, OP_STIV: begin
            mem_addr = fld;
            n_state  = ST_PTR;
          end
          OP_LDVR: begin
            mem_addr = rel_addr;
            n_state  = ST_MEM;
          end
          OP_STVR: begin
            mem_addr = rel_addr;
            mem_we   = 1'b1;
          end
          default: begin
            case (ext)
              EX_HALT: n_state = ST_HALT;
              EX_NOT, EX_RAR, EX_ADC: n_acc = alu_res;
              EX_RET:  n_iar = ra;
              EX_LDRA: n_acc = ra;
              EX_STRA: n_ra  = acc;
              EX_LDSP: n_acc = sp;
              EX_STSP: n_sp  = acc;
              EX_LDFP: n_acc = fp;
              EX_STFP: n_fp  = acc;
              default: ;
            endcase
          end
        endcase
      end
      ST_PTR: begin
        mem_addr = mem_rdata[ADDR_W-1:0];
        if (pri == OP_STIV) begin
          mem_we  = 1'b1;
          n_state = ST_FETCH;
        end else begin
          n_state = ST_MEM;
        end
      end
      ST_MEM: begin
        n_acc   = alu_res;
        n_state = ST_FETCH;
      end
      default: n_state = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      ir    <= '0;
      acc   <= '0;
      iar   <= '0;
      ra    <= '0;
      sp    <= '0;
      fp    <= '0;
    end else begin
      state <= n_state;
      ir    <= n_ir;
      acc   <= n_acc;
      iar   <= n_iar;
      ra    <= n_ra;
      sp    <= n_sp;
      fp    <= n_fp;
    end
  end
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              halted,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input state_t            state,
  input logic [3:0]        pri,
  input logic              acc_msb,
  input logic [DATA_W-1:0] iar
);
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted); // R13
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    halted |-> !mem_we); // R13
  AST_HALT_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(mem_addr)); // R13
  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH) |=> (iar == DATA_W'($past(iar) + 1'b1))); // R2
  AST_JMN_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC && pri == OP_JMN && !acc_msb) |=> $stable(iar)); // R8
  AST_WRITE_PHASE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (state == ST_EXEC || state == ST_PTR)); // R3
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .halted   (halted),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .state    (state),
  .pri      (pri),
  .acc_msb  (acc[DATA_W-1]),
  .iar      (iar)
);

// File: tb/acc_core_bench.sv
module acc_core_bench;
  localparam int DW = 24;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic [DW-1:0] mem_rdata;
  logic          halted;

  logic [DW-1:0] mem [0:255];
  logic          ld_en = 1'b0;
  logic [7:0]    ld_addr = '0;
  logic [DW-1:0] ld_data = '0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW)) u_acc_core (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[7:0]];
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [DW-1:0] d);
    ld_addr = 8'(a); ld_data = d; ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  function automatic logic [DW-1:0] pw(input logic [3:0] op, input logic [AW-1:0] f);
    return {op, f};
  endfunction

  function automatic logic [DW-1:0] xw(input logic [7:0] op, input logic [15:0] k);
    return {op, k};
  endfunction

  task automatic run_to_halt(input string req);
    int n;
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(req, {23'd0, halted}, 24'd1);
  endtask

  localparam int NV = 7;
  logic [DW-1:0] vals [0:NV-1];

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [DW-1:0] x, y, e;
    logic [AW-1:0] hold_addr;
    vals[0] = 24'h000000; vals[1] = 24'h000001; vals[2] = 24'h7FFFFF;
    vals[3] = 24'h800000; vals[4] = 24'hFFFFFF; vals[5] = 24'h123456;
    vals[6] = 24'hA5A5A5;
    @(negedge clk);
    // sweep program, words 0..32
    poke(0,  pw(4'h1, 20'h80)); poke(1,  pw(4'h3, 20'h81)); poke(2,  pw(4'h2, 20'h90));
    poke(3,  pw(4'h1, 20'h80)); poke(4,  pw(4'h4, 20'h81)); poke(5,  pw(4'h2, 20'h91));
    poke(6,  pw(4'h1, 20'h80)); poke(7,  pw(4'h5, 20'h81)); poke(8,  pw(4'h2, 20'h92));
    poke(9,  pw(4'h1, 20'h80)); poke(10, pw(4'h6, 20'h81)); poke(11, pw(4'h2, 20'h93));
    poke(12, pw(4'h1, 20'h80)); poke(13, pw(4'h7, 20'h81)); poke(14, pw(4'h2, 20'h94));
    poke(15, pw(4'h1, 20'h80)); poke(16, xw(8'hF1, 16'h0)); poke(17, pw(4'h2, 20'h95));
    poke(18, pw(4'h1, 20'h80)); poke(19, xw(8'hF2, 16'h0)); poke(20, pw(4'h2, 20'h96));
    poke(21, pw(4'h1, 20'h80)); poke(23, pw(4'h2, 20'h97));
    poke(25, pw(4'h2, 20'h98));
    poke(26, pw(4'h1, 20'h80)); poke(27, pw(4'h9, 20'd30)); poke(28, pw(4'h0, 20'd1));
    poke(29, pw(4'h8, 20'd31)); poke(30, pw(4'h0, 20'd2)); poke(31, pw(4'h2, 20'h99));
    poke(32, xw(8'hF0, 16'h0));

    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        x = vals[i];
        y = vals[j];
        rst = 1'b1;
        poke(22, xw(8'hFA, y[15:0]));
        poke(24, pw(4'h0, y[19:0]));
        poke(8'h80, x);
        poke(8'h81, y);
        for (int k = 8'h90; k <= 8'h99; k++) poke(k, 24'hDEAD00);
        if (i == 0 && j == 0) begin
          #1;
          chk("R1 reset addr", {4'h0, mem_addr}, 24'h0);
          chk("R1 reset we", {23'd0, mem_we}, 24'h0);
          chk("R1 reset halted", {23'd0, halted}, 24'h0);
        end
        run_to_halt("R13 sweep halts");
        chk("R4 ADD", mem[8'h90], x + y);
        chk("R4 AND", mem[8'h91], x & y);
        chk("R4 OR",  mem[8'h92], x | y);
        chk("R4 XOR", mem[8'h93], x ^ y);
        chk("R5 EQL", mem[8'h94], (x == y) ? 24'hFFFFFF : 24'h0);
        chk("R4 NOT", mem[8'h95], ~x);
        chk("R6 RAR", mem[8'h96], {x[0], x[23:1]});
        e = x + {{8{y[15]}}, y[15:0]};
        chk("R7 ADC", mem[8'h97], e);
        chk("R3 LDC", mem[8'h98], {4'h0, y[19:0]});
        chk("R8 JMN", mem[8'h99], x[23] ? 24'd2 : 24'd1);
      end
    end

    // second program
    rst = 1'b1;
    for (int k = 0; k < 64; k++) poke(k, xw(8'hF0, 16'h0));
    poke(0,  pw(4'h0, 20'h40));      poke(1,  xw(8'hF9, 16'h0));
    poke(2,  pw(4'hD, 20'h2));       poke(3,  pw(4'h2, 20'hA0));
    poke(4,  pw(4'h0, 20'h55));      poke(5,  pw(4'hE, 20'hFFFFF));
    poke(6,  pw(4'hA, 20'h50));      poke(7,  pw(4'h2, 20'hA1));
    poke(8,  pw(4'h0, 20'h77));      poke(9,  pw(4'hB, 20'h51));
    poke(10, pw(4'hC, 20'd34));      poke(11, pw(4'h2, 20'hA2));
    poke(12, xw(8'hF4, 16'h0));      poke(13, pw(4'h2, 20'hA3));
    poke(14, pw(4'h0, 20'h123));     poke(15, xw(8'hF7, 16'h0));
    poke(16, pw(4'h0, 20'h0));       poke(17, xw(8'hF6, 16'h0));
    poke(18, pw(4'h2, 20'hA4));      poke(19, pw(4'h0, 20'd26));
    poke(20, xw(8'hF5, 16'h0));      poke(21, xw(8'hF3, 16'h0));
    poke(22, pw(4'h0, 20'hBAD));     poke(23, pw(4'h2, 20'hA6));
    poke(26, pw(4'h0, 20'h11));      poke(27, pw(4'h2, 20'hA6));
    poke(34, xw(8'hF8, 16'h0));      poke(35, pw(4'h2, 20'hA5));
    poke(36, pw(4'h0, 20'h99));      poke(37, xw(8'hF3, 16'h0));
    poke(8'h3F, 24'h0); poke(8'h42, 24'hABCDEF);
    poke(8'h50, 24'h000060); poke(8'h60, 24'h654321);
    poke(8'h51, 24'hF00061); poke(8'h61, 24'h0);
    for (int k = 8'hA0; k <= 8'hA6; k++) poke(k, 24'hDEAD00);
    run_to_halt("R13 program halts");
    chk("R11 LDVR", mem[8'hA0], 24'hABCDEF);
    chk("R11 STVR negative offset", mem[8'h3F], 24'h55);
    chk("R10 LDIV", mem[8'hA1], 24'h654321);
    chk("R10 STIV", mem[8'h61], 24'h77);
    chk("R9 CALL/RET", mem[8'hA2], 24'h99);
    chk("R9 LDRA", mem[8'hA3], 24'd11);
    chk("R12 SP move", mem[8'hA4], 24'h123);
    chk("R12 FP move", mem[8'hA5], 24'h40);
    chk("R9 STRA then RET", mem[8'hA6], 24'h11);
    chk("R2 fetch order", mem[8'h3E], xw(8'hF0, 16'h0));

    hold_addr = mem_addr;
    e = mem[8'hA6];
    repeat (16) begin
      @(negedge clk);
      chk("R13 halted stays", {23'd0, halted}, 24'd1);
      chk("R13 no write", {23'd0, mem_we}, 24'd0);
      chk("R13 addr frozen", {4'h0, mem_addr}, {4'h0, hold_addr});
    end
    chk("R13 memory untouched", mem[8'hA6], e);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule